// File: doc/BRIEF.md
# Prescaled Periodic Down-Counter Timer

This block is a periodic interval timer. A down-counter as wide as the bus is loaded from a period register. It steps down by one on each tick of a programmable prescaler. When a tick finds the counter at zero, the block reloads the counter from the period register and records a zero event. A zero event raises a sticky flag and, when enabled, a one-cycle interrupt pulse. Software starts and stops the timer, forces a reload, and picks how the timer reacts to a debug-halt input. The halt can be ignored, can freeze counting at once, or can let one more decrement happen before counting freezes.

Registers are reached through a single-cycle port. A write is taken on the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`. This is a register port, not a stream, so it has no valid/ready handshake and no back-pressure: every write completes in the cycle it is presented. `dbg_halt` and `irq_o` are plain level and pulse pins.

Top module: `pdt_timer`

## Requirements
- R1: After reset, the count reads 0xFFFFFFFF, the period reads 0xFFFFFFFF, the prescale register reads 0 and control reads 0x1 (stopped, interrupt disabled, flag clear, hard-stop debug mode).
- R2: Register addresses are: 0 for the count (read only, writes ignored), 1 for the period, 2 for the prescale register (bits [15:0] divider, bits [31:16] remaining prescale count, read only), and 3 for control. Control bits are: 0 stop, 1 reload command (always reads 0), 2 interrupt enable, 3 zero flag, 4 free-run, 5 soft-stop. Read data follows `bus_addr` in the same cycle.
- R3: While running and not frozen, the count drops by exactly one once every divider+1 clock cycles.
- R4: A tick that finds the count at 0 is a zero event and loads the count from the period register, so zero events repeat every (period+1)*(divider+1) cycles.
- R5: `irq_o` is high for the single cycle after each zero-event edge, and only when the interrupt enable bit was 1.
- R6: The flag is set by every zero event, whatever the enable bit, and is cleared by writing 1 to control bit 3. A zero event in the same cycle as the clear leaves it set.
- R7: While the stop bit is 1, the count and the prescale count hold. Clearing the stop bit resumes from the held values.
- R8: Writing 1 to control bit 1 copies the period into the count and the divider into the prescale count. It takes priority over a tick in that cycle and also works while stopped.
- R9: A period write leaves the running count untouched. The new value is used only at the next reload or zero event.
- R10: With free-run (bit 4) set, `dbg_halt` has no effect on counting.
- R11: With bits 4 and 5 both clear, counting is frozen in every cycle that `dbg_halt` is high.
- R12: With bit 4 clear and bit 5 set, once `dbg_halt` rises the count performs exactly one more decrement and then freezes until `dbg_halt` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| dbg_halt | input | 1 | Debug halt request |
| irq_o | output | 1 | Zero-event interrupt pulse |

## Verification
The embedded properties check a set of rules on every cycle:
- the decrement-by-one step and the prescaler reload;
- that the flag is set after every zero event;
- that no interrupt appears without the enable bit;
- that the count holds while stopped or during a period write;
- that no tick occurs under a hard-stop halt.

Other behaviours are properties of whole scenarios and are left to the bench. These are the event spacing of (period+1)*(divider+1), the single extra decrement in soft-stop mode, the flag clear losing to a same-cycle event, and free-run ignoring the halt. The bench compares every read and every interrupt cycle against a reference model under random register traffic.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT    = 2'd0,
    SEL_PERIOD   = 2'd1,
    SEL_PRESCALE = 2'd2,
    SEL_CTRL     = 2'd3
  } reg_sel_e;

  localparam int CB_STOP   = 0;
  localparam int CB_RELOAD = 1;
  localparam int CB_IEN    = 2;
  localparam int CB_FLAG   = 3;
  localparam int CB_FREE   = 4;
  localparam int CB_SOFT   = 5;
  localparam int CTRL_USED = 6;
endpackage

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             en_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] psc_o
);
  logic [DIV_W-1:0] psc_q;

  assign tick_o = en_i && !load_i && (psc_q == '0);
  assign psc_o  = psc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          psc_q <= '0;
    else if (load_i)     psc_q <= div_i;
    else if (en_i) begin
      if (psc_q == '0)   psc_q <= div_i;
      else               psc_q <= psc_q - 1'b1;
    end
  end

  assert_psc_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (psc_q == $past(div_i)));
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_evt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o      = cnt_q;
  assign zero_evt_o = tick_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '1;
    else if (load_i)      cnt_q <= period_i;
    else if (tick_i) begin
      if (cnt_q == '0)    cnt_q <= period_i;
      else                cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_dec_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_zero_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt_o |=> (cnt_q == $past(period_i)));
endmodule

// File: rtl/pdt_halt_ctl.sv
module pdt_halt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_i,
  input  logic free_i,
  input  logic soft_i,
  input  logic tick_i,
  output logic freeze_o
);
  logic soft_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       soft_done_q <= 1'b0;
    else if (!halt_i) soft_done_q <= 1'b0;
    else if (tick_i)  soft_done_q <= 1'b1;
  end

  assign freeze_o = halt_i && !free_i && (!soft_i || soft_done_q);
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
  import pdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             dbg_halt,
  output logic             irq_o
);
  localparam int DATA_W = CNT_W;

  logic [CNT_W-1:0] period_q;
  logic [DIV_W-1:0] div_q;
  logic stop_q, ien_q, flag_q, free_q, soft_q, irq_q;

  logic ctrl_wr, per_wr, div_wr, reload_cmd, flag_clr;
  logic freeze, run_en, tick, zero_evt;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] psc;

  assign ctrl_wr    = bus_we && (bus_addr == SEL_CTRL);
  assign per_wr     = bus_we && (bus_addr == SEL_PERIOD);
  assign div_wr     = bus_we && (bus_addr == SEL_PRESCALE);
  assign reload_cmd = ctrl_wr && bus_wdata[CB_RELOAD];
  assign flag_clr   = ctrl_wr && bus_wdata[CB_FLAG];
  assign run_en     = !stop_q && !freeze;

  pdt_halt_ctl u_halt (
    .clk(clk), .rst_n(rst_n), .halt_i(dbg_halt), .free_i(free_q),
    .soft_i(soft_q), .tick_i(tick), .freeze_o(freeze)
  );

  pdt_prescaler #(.DIV_W(DIV_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .load_i(reload_cmd), .div_i(div_q),
    .en_i(run_en), .tick_o(tick), .psc_o(psc)
  );

  pdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(reload_cmd), .period_i(period_q),
    .tick_i(tick), .cnt_o(cnt), .zero_evt_o(zero_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '1;
      div_q    <= '0;
      stop_q   <= 1'b1;
      ien_q    <= 1'b0;
      free_q   <= 1'b0;
      soft_q   <= 1'b0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (per_wr) period_q <= bus_wdata;
      if (div_wr) div_q    <= bus_wdata[DIV_W-1:0];
      if (ctrl_wr) begin
        stop_q <= bus_wdata[CB_STOP];
        ien_q  <= bus_wdata[CB_IEN];
        free_q <= bus_wdata[CB_FREE];
        soft_q <= bus_wdata[CB_SOFT];
      end
      if (zero_evt)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      irq_q <= zero_evt && ien_q;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      SEL_COUNT:    bus_rdata = cnt;
      SEL_PERIOD:   bus_rdata = period_q;
      SEL_PRESCALE: begin
        bus_rdata[DIV_W-1:0]       = div_q;
        bus_rdata[2*DIV_W-1:DIV_W] = psc;
      end
      default: begin
        bus_rdata[CB_STOP] = stop_q;
        bus_rdata[CB_IEN]  = ien_q;
        bus_rdata[CB_FLAG] = flag_q;
        bus_rdata[CB_FREE] = free_q;
        bus_rdata[CB_SOFT] = soft_q;
      end
    endcase
  end

  initial begin
    assert_width_fit_R2: assert (DATA_W >= 2*DIV_W && DATA_W >= CTRL_USED);
  end

  assert_irq_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(ien_q));
  assert_flag_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> flag_q);
  assert_stop_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !reload_cmd) |=> ($stable(cnt) && $stable(psc)));
  assert_period_wr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (per_wr && !tick) |=> $stable(cnt));
  assert_hard_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !free_q && !soft_q) |-> !tick);
endmodule

// File: tb/pdt_timer_bench.sv
`timescale 1ns/1ps
module pdt_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic dbg_halt = 1'b0;
  logic irq_o;

  always #2 clk = ~clk;

  pdt_timer u_pdt_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt), .irq_o(irq_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [31:0] m_cnt, m_per;
  logic [15:0] m_psc, m_div;
  logic m_stop, m_ien, m_flag, m_free, m_soft, m_sdone, m_irq;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(input logic [1:0] a);
    case (a)
      2'd0: mread = m_cnt;
      2'd1: mread = m_per;
      2'd2: mread = {m_psc, m_div};
      default: mread = {26'd0, m_soft, m_free, m_flag, m_ien, 1'b0, m_stop};
    endcase
  endfunction

  function automatic string sel_req(input logic [1:0] a);
    case (a)
      2'd0: sel_req = "R3";
      2'd1: sel_req = "R9";
      2'd2: sel_req = "R8";
      default: sel_req = "R6";
    endcase
  endfunction

  task automatic model_init();
    m_cnt = '1; m_per = '1; m_psc = '0; m_div = '0;
    m_stop = 1; m_ien = 0; m_flag = 0; m_free = 0; m_soft = 0; m_sdone = 0; m_irq = 0;
  endtask

  task automatic model_step(input logic we, input logic [1:0] a, input logic [31:0] wd, input logic h);
    logic rl, clr, fz, en, tk, zv;
    rl  = we && a == 2'd3 && wd[1];
    clr = we && a == 2'd3 && wd[3];
    fz  = h && !m_free && (!m_soft || m_sdone);
    en  = !m_stop && !fz;
    tk  = en && !rl && (m_psc == 0);
    zv  = tk && (m_cnt == 0);
    m_irq = zv && m_ien;
    if (zv) m_flag = 1; else if (clr) m_flag = 0;
    if (!h) m_sdone = 0; else if (tk) m_sdone = 1;
    if (rl) begin
      m_cnt = m_per; m_psc = m_div;
    end else begin
      if (en) m_psc = (m_psc == 0) ? m_div : m_psc - 1'b1;
      if (tk) m_cnt = (m_cnt == 0) ? m_per : m_cnt - 1'b1;
    end
    if (we) begin
      case (a)
        2'd1: m_per = wd;
        2'd2: m_div = wd[15:0];
        2'd3: begin m_stop = wd[0]; m_ien = wd[2]; m_free = wd[4]; m_soft = wd[5]; end
        default: ;
      endcase
    end
  endtask

  // drives at the falling edge, checks 1 ns after the rising edge
  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] wd, input logic h);
    bus_we = we; bus_addr = a; bus_wdata = wd; dbg_halt = h;
    model_step(we, a, wd, h);
    @(posedge clk); #1;
    chk("R5", {31'd0, irq_o}, {31'd0, m_irq});
    chk(sel_req(a), bus_rdata, mread(a));
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic h);
    step(1'b0, a, 32'd0, h);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int last_irq, gaps;
    void'($urandom(32'h5EED_0042));
    model_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], 1'b0);
      case (a)
        0: chk("R1", bus_rdata, 32'hFFFF_FFFF);
        1: chk("R1", bus_rdata, 32'hFFFF_FFFF);
        2: chk("R1", bus_rdata, 32'h0);
        default: chk("R1", bus_rdata, 32'h1);
      endcase
    end
    // R2 count is read only
    step(1'b1, 2'd0, 32'h1234, 1'b0);
    rd(2'd0, 1'b0);
    chk("R2", bus_rdata, 32'hFFFF_FFFF);

    // R4/R5 spacing: period 3, divider 2 -> 12 cycles
    step(1'b1, 2'd1, 32'd3, 1'b0);
    step(1'b1, 2'd2, 32'd2, 1'b0);
    step(1'b1, 2'd3, 32'h06, 1'b0);
    last_irq = -1; gaps = 0;
    for (int i = 0; i < 60; i++) begin
      rd(2'd0, 1'b0);
      if (irq_o) begin
        if (last_irq >= 0) begin chk("R4", i - last_irq, 12); gaps++; end
        last_irq = i;
      end
    end
    chk("R4", {31'd0, gaps >= 3}, 32'd1);

    // R6 flag: set wins over clear with period 0, divider 0
    step(1'b1, 2'd1, 32'd0, 1'b0);
    step(1'b1, 2'd2, 32'd0, 1'b0);
    step(1'b1, 2'd3, 32'h06, 1'b0);
    step(1'b1, 2'd3, 32'h0C, 1'b0);
    chk("R6", {31'd0, bus_rdata[3]}, 32'd1);
    step(1'b1, 2'd3, 32'h01, 1'b0);
    step(1'b1, 2'd3, 32'h09, 1'b0);
    chk("R6", {31'd0, bus_rdata[3]}, 32'd0);

    // R8 reload while stopped
    step(1'b1, 2'd1, 32'd50, 1'b0);
    step(1'b1, 2'd3, 32'h03, 1'b0);
    rd(2'd0, 1'b0);
    chk("R8", bus_rdata, 32'd50);

    // R7 stop holds, resume continues
    for (int i = 0; i < 8; i++) rd(2'd0, 1'b0);
    chk("R7", bus_rdata, 32'd50);
    step(1'b1, 2'd3, 32'h00, 1'b0);
    rd(2'd0, 1'b0);
    chk("R7", bus_rdata, 32'd49);

    // R9 period write does not disturb the count
    v = bus_rdata;
    step(1'b1, 2'd1, 32'd9, 1'b0);
    rd(2'd0, 1'b0);
    chk("R9", bus_rdata, v - 2);

    // R11 hard stop
    step(1'b1, 2'd3, 32'h00, 1'b0);
    rd(2'd0, 1'b0);
    v = bus_rdata;
    for (int i = 0; i < 5; i++) rd(2'd0, 1'b1);
    chk("R11", bus_rdata, v);

    // R10 free run ignores halt
    step(1'b1, 2'd1, 32'd1000, 1'b0);
    step(1'b1, 2'd3, 32'h12, 1'b0);
    rd(2'd0, 1'b0);
    v = bus_rdata;
    for (int i = 0; i < 5; i++) rd(2'd0, 1'b1);
    chk("R10", bus_rdata, v - 5);

    // R12 soft stop: one more decrement
    step(1'b1, 2'd3, 32'h22, 1'b0);
    rd(2'd0, 1'b0);
    v = bus_rdata;
    for (int i = 0; i < 5; i++) rd(2'd0, 1'b1);
    chk("R12", bus_rdata, v - 1);
    rd(2'd0, 1'b0);
    chk("R12", bus_rdata, v - 2);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic we;
      logic [1:0] a;
      logic [31:0] wd;
      we = ($urandom_range(0, 3) == 0);
      a  = 2'($urandom_range(0, 3));
      wd = $urandom;
      if (a == 2'd1) wd = wd & 32'h1F;
      if (a == 2'd2) wd = wd & 32'h3;
      if (a == 2'd3) wd = wd & 32'h3E;
      if (($urandom_range(0, 15)) == 0) dbg_halt = ~dbg_halt;
      step(we, a, wd, dbg_halt);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule